// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This receiver turns a three-wire serial stereo stream into parallel sample pairs. The three wires are a bit clock, a data line and a left/right word clock. All three inputs must be synchronous to the system clock `clk`, and the bit clock may run at no more than half the system-clock rate. The block watches for rising edges of the bit clock and takes one data bit at each of them, MSB first, in two's complement. Each bit-clock edge is also checked for a change in the word clock.

Two framings are supported. In the right-justified framing, the word sits at the end of each word-clock half period and a high word clock marks the left channel. In the I2S framing, the word begins one bit clock after the word-clock change and a low word clock marks the left channel. A hardware-mode pin forces 16-bit right-justified reception. When that pin is low, two register bits supplied as inputs choose the framing and, for I2S only, a 16- or 18-bit word. Every sample is presented on an 18-bit scale. When a left word and the right word that follows it have both been captured, the two outputs update together and a one-cycle `valid_o` strobe is issued.

The frame controller has four states. `ST_SYNC` waits for the first word-clock change after reset. `ST_STREAM` is the right-justified state, and it captures at every word-clock change. `ST_COLLECT` counts the I2S word bits. `ST_DONE` ignores the I2S bits that arrive after a word is complete. The named transitions are:
- sync-to-stream: the first change with right-justified framing in effect.
- sync-to-collect: the first change with I2S framing in effect.
- collect-to-done: the last word bit arrives.
- done-to-collect: the next word-clock change.
- collect restart: a word-clock change arrives before the word is complete.

Top module: `dual_fmt_audio_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `left_o` and `right_o` read zero and `valid_o` is low.
- R2: Data and word clock are sampled only on rising edges of the bit clock. Changes of `sdata_i` while the bit clock is high or falling have no effect.
- R3: In right-justified framing, a high word clock is the left channel. The word is the 16 bits sampled on the 16 bit-clock edges just before the edge that first sees the word clock change. Earlier bits in the same half period are ignored.
- R4: In I2S framing, a low word clock is the left channel. The MSB is the bit sampled on the second rising bit-clock edge after the word-clock change. Exactly the word length in bits is taken, and any later bits in that half period are ignored.
- R5: With `hw_mode_i` low, `len18_i` selects an 18-bit I2S word when 1 and a 16-bit I2S word when 0. Right-justified framing always uses 16 bits.
- R6: With `hw_mode_i` high, reception is 16-bit right-justified whatever the values of `fmt_i2s_i` and `len18_i`.
- R7: A 16-bit word w is output as w shifted left by two, with zeros in bits 1:0. An 18-bit word is output unchanged.
- R8: `valid_o` pulses for exactly one system-clock cycle. The pulse falls in the cycle after the bit-clock edge that completes a right word, and only if a left word was captured since the previous pulse. `left_o` and `right_o` change only together with the pulse.
- R9: After reset, the first word-clock change only synchronises the receiver. Nothing sampled before it is ever output.
- R10: In I2S framing, a half period that ends before the full word has arrived yields no word. A frame whose left half was cut short produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Left/right word clock |
| sdata_i | input | 1 | Serial data, MSB first |
| hw_mode_i | input | 1 | 1: fixed 16-bit right-justified reception |
| fmt_i2s_i | input | 1 | Register bit: 1 selects I2S framing, 0 right-justified |
| len18_i | input | 1 | Register bit 0: 1 selects 18-bit I2S words |
| left_o | output | 18 | Left sample, 18-bit scale |
| right_o | output | 18 | Right sample, 18-bit scale |
| valid_o | output | 1 | One-cycle strobe: new sample pair |

## Verification
In right-justified framing, the capture of a right word and the resulting strobe happen on the very edge where the word clock rises. That same edge restarts the left-channel half period and shifts in its first bit. The bench sends frames back to back with no idle bit clocks, so these events always coincide. A cycle-by-cycle reference then checks two things: that the strobe carries the previous frame's pair, and that the following frame still decodes correctly. I2S half periods cut exactly at word length plus one bit, and cut shorter, exercise the same collision between word completion and a word-clock change.

// File: rtl/dfar_pkg.sv
package dfar_pkg;
    typedef enum logic [1:0] {
        ST_SYNC,
        ST_STREAM,
        ST_COLLECT,
        ST_DONE
    } rx_state_t;
endpackage

// File: rtl/dfar_bit_front.sv
module dfar_bit_front (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic lrck_i,
    output logic stb_o,
    output logic chg_o,
    output logic lr_now_o,
    output logic lr_last_o
);
    logic bck_q;
    logic lr_last_q;
    logic seen_q;

    // a rising bit-clock edge is seen one system clock after it happens
    assign stb_o     = bck_i && !bck_q;
    assign lr_now_o  = lrck_i;
    assign lr_last_o = lr_last_q;
    assign chg_o     = stb_o && seen_q && (lrck_i != lr_last_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_q     <= 1'b0;
            lr_last_q <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            bck_q <= bck_i;
            if (stb_o) begin
                lr_last_q <= lrck_i;
                seen_q    <= 1'b1;
            end
        end
    end

    // two edges can never be detected back to back
    p_stb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);
endmodule

// File: rtl/dfar_shift.sv
module dfar_shift #(
    parameter int LONG_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic              bit_i,
    output logic [LONG_W-1:0] sr_q_o,
    output logic [LONG_W-1:0] sr_nx_o
);
    logic [LONG_W-1:0] sr_q;

    assign sr_nx_o = {sr_q[LONG_W-2:0], bit_i};
    assign sr_q_o  = sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (stb_i) begin
            sr_q <= sr_nx_o;
        end
    end
endmodule

// File: rtl/dfar_frame_fsm.sv
module dfar_frame_fsm
    import dfar_pkg::*;
#(
    parameter int SHORT_W = 16,
    parameter int LONG_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic              chg_i,
    input  logic              lr_now_i,
    input  logic              lr_last_i,
    input  logic [LONG_W-1:0] sr_q_i,
    input  logic [LONG_W-1:0] sr_nx_i,
    input  logic              hw_mode_i,
    input  logic              fmt_i2s_i,
    input  logic              len18_i,
    output logic [LONG_W-1:0] left_o,
    output logic [LONG_W-1:0] right_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(LONG_W + 1);
    localparam int PAD_W = LONG_W - SHORT_W;
    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(LONG_W);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, word_len;
    logic              use_i2s, use_long;
    logic              cap, cap_left;
    logic [LONG_W-1:0] raw, scaled, left_hold;
    logic              have_left;

    // hardware mode overrides both register bits
    assign use_i2s  = !hw_mode_i && fmt_i2s_i;
    assign use_long = use_i2s && len18_i;
    assign word_len = use_long ? LEN_L : LEN_S;
    assign cnt_inc  = cnt_q + 1'b1;
    assign scaled   = use_long ? raw : (raw << PAD_W);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and capture decision
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        cap      = 1'b0;
        cap_left = 1'b0;
        raw      = '0;
        if (stb_i) begin
            unique case (state_q)
                ST_SYNC: begin
                    if (chg_i) begin
                        state_d = use_i2s ? ST_COLLECT : ST_STREAM;
                        cnt_d   = '0;
                    end
                end
                ST_STREAM: begin
                    if (chg_i) begin
                        cap      = 1'b1;
                        raw      = sr_q_i;
                        cap_left = lr_last_i;
                    end
                end
                ST_COLLECT: begin
                    if (chg_i) begin
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc;
                        if (cnt_inc == word_len) begin
                            cap      = 1'b1;
                            raw      = sr_nx_i;
                            cap_left = !lr_now_i;
                            state_d  = ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (chg_i) begin
                        state_d = ST_COLLECT;
                        cnt_d   = '0;
                    end
                end
                default: state_d = ST_SYNC;
            endcase
        end
    end

    // outputs: pair left with the following right word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
            left_hold <= '0;
            have_left <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (cap) begin
                if (cap_left) begin
                    left_hold <= scaled;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_o    <= left_hold;
                    right_o   <= scaled;
                    valid_o   <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

    p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_after_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(stb_i));

    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    p_hw_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode_i && state_q == ST_SYNC && chg_i) |=> (state_q == ST_STREAM));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LEN_L);
endmodule

// File: rtl/dual_fmt_audio_rx.sv
module dual_fmt_audio_rx #(
    parameter int SHORT_W = 16,
    parameter int LONG_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_i,
    input  logic              lrck_i,
    input  logic              sdata_i,
    input  logic              hw_mode_i,
    input  logic              fmt_i2s_i,
    input  logic              len18_i,
    output logic [LONG_W-1:0] left_o,
    output logic [LONG_W-1:0] right_o,
    output logic              valid_o
);
    logic              stb, chg, lr_now, lr_last;
    logic [LONG_W-1:0] sr_q, sr_nx;

    dfar_bit_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .bck_i     (bck_i),
        .lrck_i    (lrck_i),
        .stb_o     (stb),
        .chg_o     (chg),
        .lr_now_o  (lr_now),
        .lr_last_o (lr_last)
    );

    dfar_shift #(.LONG_W(LONG_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (stb),
        .bit_i   (sdata_i),
        .sr_q_o  (sr_q),
        .sr_nx_o (sr_nx)
    );

    dfar_frame_fsm #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (stb),
        .chg_i     (chg),
        .lr_now_i  (lr_now),
        .lr_last_i (lr_last),
        .sr_q_i    (sr_q),
        .sr_nx_i   (sr_nx),
        .hw_mode_i (hw_mode_i),
        .fmt_i2s_i (fmt_i2s_i),
        .len18_i   (len18_i),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o)
    );
endmodule

// File: tb/dual_fmt_audio_rx_test.sv
`timescale 1ns/1ps
module dual_fmt_audio_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bck = 1'b0, lrck = 1'b0, sd = 1'b0;
    logic hw = 1'b0, fmt = 1'b0, l18 = 1'b0;
    logic [17:0] left_o, right_o;
    logic valid_o;
    int checks = 0;
    int failures = 0;
    bit done = 0;
    int lv[4];
    int rv[4];

    always #4 clk = ~clk;

    dual_fmt_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .bck_i(bck), .lrck_i(lrck), .sdata_i(sd),
        .hw_mode_i(hw), .fmt_i2s_i(fmt), .len18_i(l18),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    function automatic logic [17:0] scale(input int w, input int len);
        if (len == 16) return 18'((w & 32'hFFFF) << 2);
        return 18'(w & 32'h3FFFF);
    endfunction

    function automatic logic junk(input int k);
        return ((k * 5 + 3) % 7) < 3;
    endfunction

    task automatic tick(input bit ev, input logic [17:0] el, input logic [17:0] er, input string tag);
        @(negedge clk);
        checks++;
        if (valid_o !== ev) begin
            failures++;
            $display("FAIL %s valid=%0b expected=%0b at %0t", tag, valid_o, ev, $time);
        end
        if (ev) begin
            checks += 2;
            if (left_o !== el) begin
                failures++;
                $display("FAIL %s left=%h expected=%h", tag, left_o, el);
            end
            if (right_o !== er) begin
                failures++;
                $display("FAIL %s right=%h expected=%h", tag, right_o, er);
            end
        end
    endtask

    // one bit-clock period = four system clocks
    task automatic bit_edge(input logic lr, input logic d, input bit ev,
                            input logic [17:0] el, input logic [17:0] er, input string tag);
        bck = 1'b0; lrck = lr; sd = d;
        tick(0, '0, '0, "R8");
        tick(0, '0, '0, "R8");
        bck = 1'b1;
        tick(ev, el, er, tag);
        sd = ~d; // R2: data moving while the bit clock is high must not matter
        tick(0, '0, '0, "R2/R8");
    endtask

    task automatic send_half(input logic lr, input int word, input int wlen, input int nbits,
                             input bit i2s, input int vidx, input logic [17:0] el,
                             input logic [17:0] er, input string tag);
        for (int k = 0; k < nbits; k++) begin
            logic d;
            d = junk(k);
            if (!i2s && k >= nbits - wlen) d = word[wlen - 1 - (k - (nbits - wlen))];
            if (i2s && k >= 1 && k <= wlen) d = word[wlen - k];
            bit_edge(lr, d, (k == vidx), el, er, tag);
        end
    endtask

    task automatic do_reset(input logic h, input logic f, input logic l);
        rst_n = 1'b0; bck = 1'b0; lrck = 1'b0; sd = 1'b0;
        hw = h; fmt = f; l18 = l;
        repeat (3) @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0) begin
            failures++;
            $display("FAIL R1 in reset valid=%0b left=%h right=%h expected 0 0 0", valid_o, left_o, right_o);
        end
        rst_n = 1'b1;
        tick(0, '0, '0, "R1");
        checks++;
        if (left_o !== '0 || right_o !== '0) begin
            failures++;
            $display("FAIL R1 after reset left=%h right=%h expected 0 0", left_o, right_o);
        end
    endtask

    // right-justified: pair of frame i is reported when frame i+1 starts
    task automatic run_rj(input int h, input int n, input string tag);
        send_half(1'b0, 0, 16, 6, 0, -1, '0, '0, "R9");
        for (int i = 0; i < n; i++) begin
            if (i == 0) send_half(1'b1, lv[i], 16, h, 0, -1, '0, '0, tag);
            else send_half(1'b1, lv[i], 16, h, 0, 0, scale(lv[i-1], 16), scale(rv[i-1], 16), tag);
            send_half(1'b0, rv[i], 16, h, 0, -1, '0, '0, tag);
        end
        send_half(1'b1, 0, 16, 4, 0, 0, scale(lv[n-1], 16), scale(rv[n-1], 16), tag);
    endtask

    task automatic run_i2s(input int wl, input int h, input int n, input string tag);
        send_half(1'b1, 0, wl, 6, 1, -1, '0, '0, "R9");
        for (int i = 0; i < n; i++) begin
            send_half(1'b0, lv[i], wl, h, 1, -1, '0, '0, tag);
            send_half(1'b1, rv[i], wl, h, 1, wl, scale(lv[i], wl), scale(rv[i], wl), tag);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // hardware mode ignores I2S/18-bit register settings (R6, R3, R7)
        do_reset(1'b1, 1'b1, 1'b1);
        lv[0] = 'h1234; rv[0] = 'hEDCB; lv[1] = 'h7FFF; rv[1] = 'h8000;
        lv[2] = 'h0001; rv[2] = 'hFFFF;
        run_rj(24, 3, "R6/R3/R7");

        // register mode right-justified stays 16 bit even with len18 set, no spare bits (R5, R3)
        do_reset(1'b0, 1'b0, 1'b1);
        lv[0] = 'hA5A5; rv[0] = 'h5A5A; lv[1] = 'h8001; rv[1] = 'h7FFE;
        run_rj(16, 2, "R5/R3");

        // I2S 16-bit, half period exactly word length plus one (R4, R7)
        do_reset(1'b0, 1'b1, 1'b0);
        lv[0] = 'hC3C3; rv[0] = 'h0F0F; lv[1] = 'h8000; rv[1] = 'h7FFF;
        run_i2s(16, 17, 2, "R4/R7");

        // I2S 18-bit with spare bits after the word (R5, R4)
        do_reset(1'b0, 1'b1, 1'b1);
        lv[0] = 'h1FFFF; rv[0] = 'h20000; lv[1] = 'h0A5A5; rv[1] = 'h3FFFF;
        lv[2] = 'h00001; rv[2] = 'h2AAAA;
        run_i2s(18, 32, 3, "R5/R4");

        // I2S cut-short left half drops the frame, next frame recovers (R10)
        do_reset(1'b0, 1'b1, 1'b0);
        send_half(1'b1, 0, 16, 6, 1, -1, '0, '0, "R9");
        send_half(1'b0, 'h1111, 16, 10, 1, -1, '0, '0, "R10");
        send_half(1'b1, 'h2222, 16, 24, 1, -1, '0, '0, "R10");
        send_half(1'b0, 'h3333, 16, 24, 1, -1, '0, '0, "R10");
        send_half(1'b1, 'hCCCC, 16, 24, 1, 16, scale('h3333, 16), scale('hCCCC, 16), "R10");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule